// File: doc/BRIEF.md
# Bit-Manipulation Count and Rotate Unit

This block is a purely combinational execution unit for the basic bit-manipulation group of a 64-bit datapath. A 5-bit operation code selects one function. Two 64-bit operands and a word-mode flag are inputs, and one 64-bit result is the output. The unit has no state. The result follows the inputs within the same cycle, so the surrounding pipeline registers it wherever it needs to.

The functions are grouped as follows:

- Counting: leading zeros, trailing zeros and set bits.
- Logic with an inverted second operand.
- Signed and unsigned minimum and maximum.
- Byte and halfword extension.
- Rotates in both directions.
- Full byte-order reversal.
- A per-byte OR reduction that marks every non-zero byte.

When word mode is set, the counts and the rotates work on the low 32 bits of the first operand only. Word-mode rotates sign-extend their 32-bit result.

Top module: `bcr_unit`

## Requirements
- R1: With word mode clear, code 1 returns the number of zero bits above the highest set bit of the first operand, and code 2 returns the number of zero bits below the lowest set bit. Both codes return 64 for an all-zero operand.
- R2: With word mode set, codes 1 and 2 look only at bits 31..0 of the first operand and return 32 when those bits are all zero. Bits 63..32 have no effect.
- R3: Code 3 returns the number of set bits in the first operand. With word mode set, only bits 31..0 are counted.
- R4: Code 4 returns a AND NOT b, code 5 returns a OR NOT b, and code 6 returns NOT (a XOR b).
- R5: Code 7 returns the signed minimum and code 8 the signed maximum, comparing both operands as two's complement values. Code 9 returns the unsigned minimum and code 10 the unsigned maximum.
- R6: Code 11 copies bit 7 into bits 63..8. Code 12 copies bit 15 into bits 63..16. Code 13 clears bits 63..16. All three keep the low bits unchanged.
- R7: With word mode clear, code 14 rotates the first operand left and code 15 rotates it right. The rotate amount is bits 5..0 of the second operand, and its upper bits are ignored.
- R8: With word mode set, codes 14 and 15 rotate bits 31..0 of the first operand by the amount in bits 4..0 of the second operand. The 32-bit result is then sign-extended to 64 bits.
- R9: Code 16 reverses the byte order of the 64-bit first operand: byte k of the result is byte 7-k of the operand.
- R10: For code 17, each result byte is 0xFF when the matching byte of the first operand is non-zero, and 0x00 when it is zero.
- R11: Word mode has no effect on codes 4 to 13, 16 and 17.
- R12: Code 0 and every code from 18 to 31 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code (see R1 to R12) |
| word_mode | input | 1 | Use the low 32 bits for counts and rotates |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand or rotate amount |
| result | output | 64 | Combinational result |

## Verification
Every result is due in the same cycle as its stimulus, with zero register stages between inputs and output. The driver changes the operation code and operands on a falling clock edge. In the same step it queues the expected value, which comes from a bit-by-bit reference model. The monitor pops that value and compares it on the next rising edge, half a period later, when the combinational path has settled and no input is moving. Directed vectors cover these cases:

- zero inputs to every count;
- bits 63..32 that must be ignored in word mode;
- rotate amounts beyond the field width;
- sign-bit crossings for the minimum and maximum;
- unused operation codes.

Random vectors then cover all codes in both modes.

// File: rtl/bcr_unit.sv
module bcr_unit #(
  parameter int DATA_W = 64
) (
  input  logic [4:0]        op_sel,
  input  logic              word_mode,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result
);
  localparam int HALF_W = DATA_W / 2;
  localparam int NBYTES = DATA_W / 8;
  localparam int SH_W   = $clog2(DATA_W);
  localparam int SHW_W  = $clog2(HALF_W);
  localparam int CNT_W  = SH_W + 1;

  localparam logic [4:0] OP_CLZ  = 5'd1;
  localparam logic [4:0] OP_CTZ  = 5'd2;
  localparam logic [4:0] OP_CPOP = 5'd3;
  localparam logic [4:0] OP_ANDN = 5'd4;
  localparam logic [4:0] OP_ORN  = 5'd5;
  localparam logic [4:0] OP_XNOR = 5'd6;
  localparam logic [4:0] OP_MIN  = 5'd7;
  localparam logic [4:0] OP_MAX  = 5'd8;
  localparam logic [4:0] OP_MINU = 5'd9;
  localparam logic [4:0] OP_MAXU = 5'd10;
  localparam logic [4:0] OP_SXB  = 5'd11;
  localparam logic [4:0] OP_SXH  = 5'd12;
  localparam logic [4:0] OP_ZXH  = 5'd13;
  localparam logic [4:0] OP_ROL  = 5'd14;
  localparam logic [4:0] OP_ROR  = 5'd15;
  localparam logic [4:0] OP_REV  = 5'd16;
  localparam logic [4:0] OP_ORCB = 5'd17;

  logic [HALF_W-1:0] lo;
  logic [CNT_W-1:0]  lz_f, lz_w, tz_f, tz_w, pc_f, pc_w;
  logic [DATA_W-1:0] rol_f, ror_f, rev8, orcb;
  logic [HALF_W-1:0] rol_w, ror_w;
  logic [SH_W-1:0]   amt_f;
  logic [SHW_W-1:0]  amt_w;
  logic              lt_s, lt_u;

  assign lo    = opnd_a[HALF_W-1:0];
  assign amt_f = opnd_b[SH_W-1:0];
  assign amt_w = opnd_b[SHW_W-1:0];
  assign lt_s  = $signed(opnd_a) < $signed(opnd_b);
  assign lt_u  = opnd_a < opnd_b;

  always_comb begin
    lz_f = CNT_W'(DATA_W);
    tz_f = CNT_W'(DATA_W);
    pc_f = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (opnd_a[i]) lz_f = CNT_W'(DATA_W - 1 - i);
      pc_f = pc_f + CNT_W'(opnd_a[i]);
    end
    for (int i = DATA_W - 1; i >= 0; i--)
      if (opnd_a[i]) tz_f = CNT_W'(i);
  end

  always_comb begin
    lz_w = CNT_W'(HALF_W);
    tz_w = CNT_W'(HALF_W);
    pc_w = '0;
    for (int i = 0; i < HALF_W; i++) begin
      if (lo[i]) lz_w = CNT_W'(HALF_W - 1 - i);
      pc_w = pc_w + CNT_W'(lo[i]);
    end
    for (int i = HALF_W - 1; i >= 0; i--)
      if (lo[i]) tz_w = CNT_W'(i);
  end

  assign rol_f = (opnd_a << amt_f) | (opnd_a >> (CNT_W'(DATA_W) - {1'b0, amt_f}));
  assign ror_f = (opnd_a >> amt_f) | (opnd_a << (CNT_W'(DATA_W) - {1'b0, amt_f}));
  assign rol_w = (lo << amt_w) | (lo >> ((SHW_W+1)'(HALF_W) - {1'b0, amt_w}));
  assign ror_w = (lo >> amt_w) | (lo << ((SHW_W+1)'(HALF_W) - {1'b0, amt_w}));

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    assign rev8[8*k +: 8] = opnd_a[8*(NBYTES-1-k) +: 8];
    assign orcb[8*k +: 8] = {8{|opnd_a[8*k +: 8]}};
  end

  always_comb begin
    result = '0;
    case (op_sel)
      OP_CLZ:  result = DATA_W'(word_mode ? lz_w : lz_f);
      OP_CTZ:  result = DATA_W'(word_mode ? tz_w : tz_f);
      OP_CPOP: result = DATA_W'(word_mode ? pc_w : pc_f);
      OP_ANDN: result = opnd_a & ~opnd_b;
      OP_ORN:  result = opnd_a | ~opnd_b;
      OP_XNOR: result = ~(opnd_a ^ opnd_b);
      OP_MIN:  result = lt_s ? opnd_a : opnd_b;
      OP_MAX:  result = lt_s ? opnd_b : opnd_a;
      OP_MINU: result = lt_u ? opnd_a : opnd_b;
      OP_MAXU: result = lt_u ? opnd_b : opnd_a;
      OP_SXB:  result = {{(DATA_W-8){opnd_a[7]}}, opnd_a[7:0]};
      OP_SXH:  result = {{(DATA_W-16){opnd_a[15]}}, opnd_a[15:0]};
      OP_ZXH:  result = {{(DATA_W-16){1'b0}}, opnd_a[15:0]};
      OP_ROL:  result = word_mode ? {{HALF_W{rol_w[HALF_W-1]}}, rol_w} : rol_f;
      OP_ROR:  result = word_mode ? {{HALF_W{ror_w[HALF_W-1]}}, ror_w} : ror_f;
      OP_REV:  result = rev8;
      OP_ORCB: result = orcb;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/bcr_unit_chk.sv
module bcr_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic [4:0]        op_sel,
  input logic              word_mode,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [DATA_W-1:0] result
);
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    // R1: full-width count of a zero operand is the full width
    if (op_sel == 5'd1 && !word_mode && opnd_a == '0)
      a_r1_clz_zero: assert (result == DATA_W) else $error("R1 clz of zero");
    // R2: word count of zero low half is half width
    if (op_sel == 5'd2 && word_mode && opnd_a[HALF_W-1:0] == '0)
      a_r2_ctzw_zero: assert (result == HALF_W) else $error("R2 ctzw of zero");
    // R5: min/max always pick one operand
    if (op_sel >= 5'd7 && op_sel <= 5'd10)
      a_r5_minmax_pick: assert (result == opnd_a || result == opnd_b) else $error("R5 pick");
    // R8: word rotate upper half mirrors bit 31
    if ((op_sel == 5'd14 || op_sel == 5'd15) && word_mode)
      a_r8_word_rot_sext: assert (result[DATA_W-1:HALF_W] == {HALF_W{result[HALF_W-1]}})
        else $error("R8 sext");
    // R10: each byte is all-ones or all-zero, and zero where the input byte is zero
    if (op_sel == 5'd17)
      for (int k = 0; k < DATA_W / 8; k++) begin
        a_r10_orcb_bytes: assert ($countones(result[8*k +: 8]) == 0 ||
                                  $countones(result[8*k +: 8]) == 8) else $error("R10 byte");
        if (opnd_a[8*k +: 8] == 8'h00)
          a_r10_orcb_zero: assert (result[8*k +: 8] == 8'h00) else $error("R10 zero byte");
      end
    // R12: unused codes yield zero
    if (op_sel == 5'd0 || op_sel >= 5'd18)
      a_r12_unsupported_zero: assert (result == '0) else $error("R12 nonzero");
  end
endmodule

bind bcr_unit bcr_unit_chk #(.DATA_W(DATA_W)) i_bcr_unit_chk (
  .op_sel(op_sel), .word_mode(word_mode), .opnd_a(opnd_a),
  .opnd_b(opnd_b), .result(result)
);

// File: tb/test_bcr_unit.sv
module test_bcr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op_sel = '0;
  logic        word_mode = 1'b0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic [63:0] result;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  bcr_unit i_bcr_unit (
    .op_sel(op_sel), .word_mode(word_mode), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .result(result)
  );

  function automatic logic [63:0] model(input logic [4:0] op, input logic wm,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = '0;
    int w = wm ? 32 : 64;
    int n = 0;
    bit stop = 0;
    int s;
    case (op)
      1: begin
        for (int i = w - 1; i >= 0; i--)
          if (!stop) begin
            if (a[i]) stop = 1; else n++;
          end
        r = 64'(n);
      end
      2: begin
        for (int i = 0; i < w; i++)
          if (!stop) begin
            if (a[i]) stop = 1; else n++;
          end
        r = 64'(n);
      end
      3: begin
        for (int i = 0; i < w; i++) n += int'(a[i]);
        r = 64'(n);
      end
      4: r = a & ~b;
      5: r = a | ~b;
      6: r = ~(a ^ b);
      7: r = ($signed(a) <= $signed(b)) ? a : b;
      8: r = ($signed(a) >= $signed(b)) ? a : b;
      9: r = (a <= b) ? a : b;
      10: r = (a >= b) ? a : b;
      11: begin r = a & 64'hFF; for (int i = 8; i < 64; i++) r[i] = a[7]; end
      12: begin r = a & 64'hFFFF; for (int i = 16; i < 64; i++) r[i] = a[15]; end
      13: r = a & 64'hFFFF;
      14, 15: begin
        s = wm ? int'(b[4:0]) : int'(b[5:0]);
        for (int i = 0; i < w; i++)
          if (op == 14) r[(i + s) % w] = a[i];
          else          r[i] = a[(i + s) % w];
        if (wm) for (int i = 32; i < 64; i++) r[i] = r[31];
      end
      16: for (int k = 0; k < 8; k++) r[8*k +: 8] = a[8*(7-k) +: 8];
      17: for (int k = 0; k < 8; k++) r[8*k +: 8] = (a[8*k +: 8] != 0) ? 8'hFF : 8'h00;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string req_of(input logic [4:0] op, input logic wm);
    case (op)
      1, 2: return wm ? "R2" : "R1";
      3: return "R3";
      4, 5, 6: return "R4";
      7, 8, 9, 10: return "R5";
      11, 12, 13: return "R6";
      14, 15: return wm ? "R8" : "R7";
      16: return "R9";
      17: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic apply(input logic [4:0] op, input logic wm, input logic [63:0] a,
                       input logic [63:0] b, input string tag);
    @(negedge clk);
    op_sel = op; word_mode = wm; opnd_a = a; opnd_b = b;
    exp_q.push_back(model(op, wm, a, b));
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      logic [63:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (result !== e) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", t, result, e);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R12 watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    opnd_a = 64'hDEAD_BEEF_0123_4567;
    apply(5'd0, 1'b0, 64'hDEAD_BEEF_0123_4567, 64'h5, "R12 reset state zero");
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    apply(5'd1, 0, 64'h0, 64'h0, "R1 clz of zero");
    apply(5'd2, 0, 64'h0, 64'h0, "R1 ctz of zero");
    apply(5'd1, 0, 64'h0000_0100_0000_0000, 0, "R1 clz mid bit");
    apply(5'd2, 0, 64'h8000_0000_0000_0000, 0, "R1 ctz top bit");
    apply(5'd1, 1, 64'hFFFF_FFFF_0000_0000, 0, "R2 clzw low zero");
    apply(5'd2, 1, 64'hFFFF_FFFF_0000_0000, 0, "R2 ctzw low zero");
    apply(5'd1, 1, 64'hFFFF_FFFF_0000_8000, 0, "R2 clzw ignores high");
    apply(5'd2, 1, 64'h0000_0001_0010_0000, 0, "R2 ctzw bit 20");
    apply(5'd3, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R3 cpop all ones");
    apply(5'd3, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R3 cpopw all ones");
    apply(5'd3, 1, 64'hF0F0_0000_0000_0101, 0, "R3 cpopw ignores high");
    apply(5'd4, 0, 64'hFF00_FF00_1234_5678, 64'h0F0F_0F0F_FFFF_0000, "R4 andn");
    apply(5'd5, 0, 64'h0000_0000_0000_0001, 64'hFFFF_0000_FFFF_0000, "R4 orn");
    apply(5'd6, 0, 64'hAAAA_5555_0000_FFFF, 64'hAAAA_AAAA_FFFF_FFFF, "R4 xnor");
    apply(5'd7, 0, 64'h8000_0000_0000_0000, 64'h1, "R5 min signed");
    apply(5'd8, 0, 64'h8000_0000_0000_0000, 64'h1, "R5 max signed");
    apply(5'd9, 0, 64'h8000_0000_0000_0000, 64'h1, "R5 minu");
    apply(5'd10, 0, 64'h8000_0000_0000_0000, 64'h1, "R5 maxu");
    apply(5'd11, 0, 64'h1234_5678_9ABC_DE80, 0, "R6 sext byte");
    apply(5'd12, 0, 64'h1234_5678_9ABC_8001, 0, "R6 sext half");
    apply(5'd13, 0, 64'hFFFF_FFFF_FFFF_8001, 0, "R6 zext half");
    apply(5'd14, 0, 64'h8000_0000_0000_0001, 64'h0, "R7 rol by zero");
    apply(5'd14, 0, 64'h8000_0000_0000_0001, 64'hFF00_0000_0000_0043, "R7 rol amount low 6 bits");
    apply(5'd15, 0, 64'h0123_4567_89AB_CDEF, 64'd4, "R7 ror by 4");
    apply(5'd14, 1, 64'hFFFF_FFFF_4000_0001, 64'd33, "R8 rolw amount low 5 bits");
    apply(5'd15, 1, 64'h0000_0000_0000_0001, 64'd1, "R8 rorw sign extend");
    apply(5'd15, 1, 64'h1234_5678_0000_0002, 64'd0, "R8 rorw by zero");
    apply(5'd16, 0, 64'h0102_0304_0506_0708, 0, "R9 byte reverse");
    apply(5'd17, 0, 64'h0001_8000_0040_0200, 0, "R10 orcb mixed");
    apply(5'd17, 0, 64'h0, 0, "R10 orcb zero");
    apply(5'd4, 1, 64'hFFFF_0000_FFFF_0000, 64'h00FF_00FF_00FF_00FF, "R11 andn word ignored");
    apply(5'd16, 1, 64'h0102_0304_0506_0708, 0, "R11 rev8 word ignored");
    apply(5'd11, 1, 64'h0000_0000_8000_0080, 0, "R11 sext word ignored");
    apply(5'd18, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R12 code 18 zero");
    apply(5'd31, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R12 code 31 zero");

    for (int i = 0; i < 400; i++) begin
      logic [4:0]  op;
      logic        wm;
      logic [63:0] a, b;
      op = 5'($urandom_range(0, 20));
      wm = 1'($urandom);
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 4 == 0) a = a & {8{8'($urandom) & 8'h81}};
      apply(op, wm, a, b, {req_of(op, wm), " random"});
    end

    @(negedge clk);
    op_sel = '0;
    repeat (2) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule